// File: doc/BRIEF.md
# Fractional Performance Level Quantizer

This block turns a software performance request into a clock level that the clock generator can actually produce. Software writes an 8-bit fixed-point fraction of the maximum frequency. The binary point sits just below the top bit, so 0x80 means full speed. The block decodes the write into one of 33 levels, from 0 (clock stopped) to 32 (full speed). It then rounds that level up to the nearest level marked as available in a 33-bit capability mask from the clock generator.

The stored requested level and the quantized level are both registered. Any change in the quantized level raises a single-cycle strobe, so the clock generator only has to act on real transitions. A write that falls in the reserved upper code region does not change the stored state. Instead it raises a sticky error flag, which stays set until the next valid write. When the capability mask changes, the quantized level is recomputed without any new write.

Top module: `perf_level_quantizer`

## Requirements
- R1: After reset, the requested level and the quantized level both read 32, and the change strobe and the error flag are low.
- R2: A write with bit 7 clear decodes to the level given by bits [6:2]. Bits [1:0] have no effect on any output.
- R3: A write of exactly 0x80 decodes to level 32.
- R4: A write with bit 7 set and any of bits [6:0] set is reserved. It sets the error flag and leaves the requested level and the quantized level unchanged.
- R5: The error flag stays set through idle cycles and clears on the next valid write.
- R6: The quantized level is the lowest level L with L at or above the requested level and capability mask bit L set.
- R7: Levels 0 and 32 count as producible whatever mask bits 0 and 32 hold.
- R8: Both levels take their new value at the clock edge that samples the write, and they keep their old value before that edge.
- R9: A change of the capability mask updates the quantized level at the next clock edge, without any write.
- R10: The change strobe is high for exactly the cycle after an edge at which the quantized level changed, and it is low otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Request write strobe |
| wr_data | input | 8 | Fractional request, binary point below bit 7 |
| cap_mask | input | 33 | Bit i set means level i is producible |
| req_level | output | 6 | Registered decoded request level |
| qnt_level | output | 6 | Registered rounded-up level |
| lvl_chg | output | 1 | One-cycle strobe on a quantized level change |
| rsv_err | output | 1 | Sticky reserved-write flag |

## Verification
The bench writes all 256 request codes under several masks, including an empty mask, alternating masks and a sparse mask. These sweeps catch the following faults:
- A decoder that uses bits [1:0], which would split levels.
- A decoder that treats 0x81 to 0xFF as valid, or rejects 0x80.
- A search that rounds down instead of up, or that misses an implicit end level. With an empty mask, such a design would return an unsupported level or fail to return 32.

Directed steps change the mask with no write. They also check that the strobe fires only on a real change and that the error flag survives idle cycles. A design that only recomputes on writes would keep a stale level. A design that strobes on every write would pulse when the level holds.

// File: rtl/perf_pkg.sv
// Package: shared defaults for the performance level quantizer.
// Assumes the request is a fixed-point fraction with one integer bit on top.
package perf_pkg;
    localparam int REQ_W_DEF  = 8;  // request width including the integer bit
    localparam int DROP_W_DEF = 2;  // low request bits that carry no weight
endpackage

// File: rtl/perf_req_decode.sv
// Module: perf_req_decode
// Turns a fixed-point request into a level number. Values with the integer
// bit set are valid only when every fraction bit is zero (exactly 1.0).
// Assumes REQ_W > DROP_W + 1.
module perf_req_decode #(
    parameter int REQ_W     = perf_pkg::REQ_W_DEF,
    parameter int DROP_W    = perf_pkg::DROP_W_DEF,
    parameter int FRAC_W    = REQ_W - 1 - DROP_W,
    parameter int LEVEL_MAX = 1 << FRAC_W,
    parameter int LVL_W     = $clog2(LEVEL_MAX + 1)
) (
    input  logic [REQ_W-1:0] req_code,
    output logic [LVL_W-1:0] dec_level,
    output logic             dec_reserved
);
    logic             int_bit;
    logic             frac_zero;
    logic [FRAC_W-1:0] frac_kept;

    assign int_bit   = req_code[REQ_W-1];
    assign frac_zero = (req_code[REQ_W-2:0] == '0);
    assign frac_kept = req_code[REQ_W-2:DROP_W];

    // Map the integer region to the top level or to the reserved flag.
    always_comb begin
        dec_reserved = 1'b0;
        dec_level    = LVL_W'(frac_kept);
        if (int_bit) begin
            dec_level    = LVL_W'(LEVEL_MAX);
            dec_reserved = !frac_zero;
        end
    end
endmodule

// File: rtl/perf_roundup.sv
// Module: perf_roundup
// Picks the lowest producible level at or above a floor level. The two end
// levels are forced producible, so a result always exists.
// Assumes floor_lvl <= LEVEL_MAX.
module perf_roundup #(
    parameter int LEVEL_MAX = 32,
    parameter int LVL_W     = $clog2(LEVEL_MAX + 1)
) (
    input  logic [LEVEL_MAX:0] cap_mask,
    input  logic [LVL_W-1:0]   floor_lvl,
    output logic [LVL_W-1:0]   lvl_out
);
    logic [LEVEL_MAX:0] forced;
    logic [LEVEL_MAX:0] elig;

    assign forced = cap_mask | {1'b1, {(LEVEL_MAX-1){1'b0}}, 1'b1};

    // One candidate flag per level: producible and not below the floor.
    for (genvar g = 0; g <= LEVEL_MAX; g++) begin : g_elig
        assign elig[g] = forced[g] && (LVL_W'(g) >= floor_lvl);
    end

    // Priority pick of the lowest candidate level.
    always_comb begin
        lvl_out = LVL_W'(LEVEL_MAX);
        for (int i = LEVEL_MAX; i >= 0; i--) begin
            if (elig[i]) lvl_out = LVL_W'(i);
        end
    end
endmodule

// File: rtl/perf_level_regs.sv
// Module: perf_level_regs
// Holds the requested and quantized levels, the change strobe and the
// sticky reserved flag. Assumes next-state values are already resolved.
module perf_level_regs #(
    parameter int LEVEL_MAX = 32,
    parameter int LVL_W     = $clog2(LEVEL_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_ok,
    input  logic             wr_bad,
    input  logic [LVL_W-1:0] req_next,
    input  logic [LVL_W-1:0] qnt_next,
    output logic [LVL_W-1:0] req_q,
    output logic [LVL_W-1:0] qnt_q,
    output logic             chg_q,
    output logic             err_q
);
    // Level storage; resets to full speed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q <= LVL_W'(LEVEL_MAX);
            qnt_q <= LVL_W'(LEVEL_MAX);
        end else begin
            req_q <= req_next;
            qnt_q <= qnt_next;
        end
    end

    // Strobe whenever the quantized level is about to move.
    always_ff @(posedge clk) begin
        if (!rst_n) chg_q <= 1'b0;
        else        chg_q <= (qnt_next != qnt_q);
    end

    // Sticky reserved flag; a valid write clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)      err_q <= 1'b0;
        else if (wr_ok)  err_q <= 1'b0;
        else if (wr_bad) err_q <= 1'b1;
    end
endmodule

// File: rtl/perf_level_quantizer.sv
// Module: perf_level_quantizer
// Top level: decodes a fractional performance write and rounds it up to a
// producible clock level. Assumes cap_mask is synchronous to clk.
module perf_level_quantizer #(
    parameter int REQ_W     = perf_pkg::REQ_W_DEF,
    parameter int DROP_W    = perf_pkg::DROP_W_DEF,
    parameter int LEVEL_MAX = 1 << (REQ_W - 1 - DROP_W),
    parameter int LVL_W     = $clog2(LEVEL_MAX + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [REQ_W-1:0]   wr_data,
    input  logic [LEVEL_MAX:0] cap_mask,
    output logic [LVL_W-1:0]   req_level,
    output logic [LVL_W-1:0]   qnt_level,
    output logic               lvl_chg,
    output logic               rsv_err
);
    logic [LVL_W-1:0] dec_level;
    logic             dec_reserved;
    logic             wr_ok;
    logic             wr_bad;
    logic [LVL_W-1:0] req_next;
    logic [LVL_W-1:0] qnt_next;

    perf_req_decode #(
        .REQ_W(REQ_W), .DROP_W(DROP_W),
        .FRAC_W(REQ_W - 1 - DROP_W), .LEVEL_MAX(LEVEL_MAX), .LVL_W(LVL_W)
    ) u_dec (
        .req_code(wr_data), .dec_level(dec_level), .dec_reserved(dec_reserved)
    );

    // Qualify the write and select the next requested level.
    always_comb begin
        wr_ok    = wr_en && !dec_reserved;
        wr_bad   = wr_en && dec_reserved;
        req_next = wr_ok ? dec_level : req_level;
    end

    perf_roundup #(.LEVEL_MAX(LEVEL_MAX), .LVL_W(LVL_W)) u_rnd (
        .cap_mask(cap_mask), .floor_lvl(req_next), .lvl_out(qnt_next)
    );

    perf_level_regs #(.LEVEL_MAX(LEVEL_MAX), .LVL_W(LVL_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_ok(wr_ok), .wr_bad(wr_bad),
        .req_next(req_next), .qnt_next(qnt_next),
        .req_q(req_level), .qnt_q(qnt_level), .chg_q(lvl_chg), .err_q(rsv_err)
    );
endmodule

// File: rtl/perf_level_quantizer_chk.sv
// Module: perf_level_quantizer_chk
// Temporal checks on the quantizer ports, bound into every instance.
module perf_level_quantizer_chk #(
    parameter int REQ_W     = 8,
    parameter int LEVEL_MAX = 32,
    parameter int LVL_W     = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic [REQ_W-1:0]   wr_data,
    input logic [LEVEL_MAX:0] cap_mask,
    input logic [LVL_W-1:0]   req_level,
    input logic [LVL_W-1:0]   qnt_level,
    input logic               lvl_chg,
    input logic               rsv_err
);
    logic               past_ok;
    logic [LEVEL_MAX:0] cap_q;
    logic               bad_wr;
    logic               good_wr;

    assign bad_wr  = wr_en && wr_data[REQ_W-1] && (wr_data[REQ_W-2:0] != '0);
    assign good_wr = wr_en && !bad_wr;

    // Remember the mask the last edge used, with both ends forced on.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            past_ok <= 1'b0;
            cap_q   <= '1;
        end else begin
            past_ok <= 1'b1;
            cap_q   <= cap_mask | {1'b1, {(LEVEL_MAX-1){1'b0}}, 1'b1};
        end
    end

    AST_QNT_NOT_BELOW: assert property (@(posedge clk) disable iff (!rst_n)
        qnt_level >= req_level); // R6
    AST_QNT_PRODUCIBLE: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> cap_q[qnt_level]); // R7
    AST_RSV_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        bad_wr |=> rsv_err && $stable(req_level) && $stable(qnt_level)); // R4
    AST_VALID_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        good_wr |=> !rsv_err); // R5
    AST_STROBE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (lvl_chg == (qnt_level != $past(qnt_level)))); // R10
endmodule

bind perf_level_quantizer perf_level_quantizer_chk #(
    .REQ_W(REQ_W), .LEVEL_MAX(LEVEL_MAX), .LVL_W(LVL_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .cap_mask(cap_mask), .req_level(req_level), .qnt_level(qnt_level),
    .lvl_chg(lvl_chg), .rsv_err(rsv_err)
);

// File: tb/sim_perf_level_quantizer.sv
`timescale 1ns/1ps
module sim_perf_level_quantizer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = 8'h00;
    logic [32:0] cap_mask = '1;
    logic [5:0]  req_level;
    logic [5:0]  qnt_level;
    logic        lvl_chg;
    logic        rsv_err;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    int m_req = 32;
    int m_qnt = 32;
    int m_err = 0;

    always #10 clk = ~clk;

    perf_level_quantizer u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .cap_mask(cap_mask), .req_level(req_level), .qnt_level(qnt_level),
        .lvl_chg(lvl_chg), .rsv_err(rsv_err)
    );

    function automatic int round_up(input int lvl, input logic [32:0] m);
        for (int l = lvl; l <= 32; l++)
            if (l == 0 || l == 32 || m[l]) return l;
        return 32;
    endfunction

    function automatic logic [32:0] mask_of(input int k);
        case (k)
            0: return '1;
            1: return '0;
            2: return 33'h0AAAAAAAA;
            3: return 33'h155555555;
            4: return 33'h000010100;
            default: return 33'h09C35B1E6;
        endcase
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] d);
        bit rsv;
        int lvl;
        int nq;
        int ec;
        rsv = d[7] && (d != 8'h80);
        lvl = d[7] ? 32 : int'(d[6:2]);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (rsv) begin
            ec = 0;
            m_err = 1;
            chk("R4 req", req_level, m_req);
            chk("R4 qnt", qnt_level, m_qnt);
            chk("R4 err", rsv_err, 1);
        end else begin
            nq = round_up(lvl, cap_mask);
            ec = (nq != m_qnt);
            m_req = lvl;
            m_qnt = nq;
            m_err = 0;
            chk(d[7] ? "R3 req" : "R2 req", req_level, m_req);
            chk("R6 qnt", qnt_level, m_qnt);
            chk("R5 err", rsv_err, 0);
        end
        chk("R10 chg", lvl_chg, ec);
        @(negedge clk);
        chk("R10 chg drop", lvl_chg, 0);
        chk("R5 err sticky", rsv_err, m_err);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 req", req_level, 32);
        chk("R1 qnt", qnt_level, 32);
        chk("R1 chg", lvl_chg, 0);
        chk("R1 err", rsv_err, 0);
        rst_n = 1'b1;

        // R8 latency: old value before the edge, new value after it
        wr(8'h40);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = 8'h20;
        #1;
        chk("R8 before edge", req_level, 16);
        @(negedge clk);
        wr_en = 1'b0;
        chk("R8 after edge", req_level, 8);
        m_req = 8;
        m_qnt = 8;
        @(negedge clk);

        // R7 end levels forced producible under an empty mask
        cap_mask = '0;
        @(negedge clk);
        chk("R7 forced top", qnt_level, 32);
        m_qnt = 32;
        wr(8'h00);
        chk("R7 forced zero", qnt_level, 0);
        wr(8'h04);
        chk("R7 round to top", qnt_level, 32);

        // Sweeps: mask change then every request code
        for (int k = 0; k < 6; k++) begin
            int nq;
            @(negedge clk);
            cap_mask = mask_of(k);
            @(negedge clk);
            nq = round_up(m_req, cap_mask);
            chk("R9 recompute", qnt_level, nq);
            chk("R10 mask chg", lvl_chg, int'(nq != m_qnt));
            m_qnt = nq;
            for (int c = 0; c < 256; c++) wr(8'(c));
        end
        finish_run();
    end
endmodule